// File: doc/BRIEF.md
# Compact-Encoding Register ALU

This block is the purely combinational execute stage for the two-register ALU format of a 16-bit compact instruction encoding. A 4-bit opcode selects one of sixteen operations. The destination register value is also the left operand. The right operand is the source register value. The block returns the result word, a write-enable for the destination and the next condition flags. Decode and the register file stay outside. The enclosing pipeline supplies the register values and the incoming carry and overflow flags. It then commits `result_o` when `wr_en_o` is high and latches `flags_o`.

The opcode space has four groups. Bitwise logic covers AND, EOR, ORR, BIC, MVN and TST. Shifts by register amount are LSL, LSR, ASR and ROR. Add and subtract covers ADC, SBC, NEG, CMP and CMN. Multiply is MUL. Each group has its own rule for the carry and overflow flags. The three comparing opcodes compute a value but never write it back. The incoming N and Z flags are not inputs, because every opcode recomputes them.

Top module: `cr_reg_alu`

## Requirements
- R1: The opcode encoding is 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, A CMP, B CMN, C ORR, D MUL, E BIC, F MVN. The logic results are dst&src (AND, TST), dst^src, dst|src, dst&~src and ~src. `result_o` carries the computed value for every opcode, including the non-writing ones.
- R2: `flags_o` is packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. For every opcode, N equals result bit 31 and Z is set exactly when the result is zero.
- R3: `wr_en_o` is low for TST, CMP and CMN, and high for every other opcode.
- R4: The bitwise logic opcodes (AND, EOR, ORR, BIC, MVN, TST) pass C and V through from `cflag_i` and `vflag_i`. The shift opcodes also pass V through.
- R5: For LSL with amount a taken from the source's low byte: a=1..31 gives dst<<a with C=dst[32-a]. a=32 gives 0 with C=dst[0]. a>32 gives 0 with C=0.
- R6: For LSR with amount a: a=1..31 gives dst>>a with C=dst[a-1]. a=32 gives 0 with C=dst[31]. a>32 gives 0 with C=0.
- R7: For ASR with amount a: a=1..31 gives the sign-filling shift with C=dst[a-1]. For a>=32, every result bit and C equal dst[31].
- R8: For ROR with a nonzero amount, the result is dst rotated right by a mod 32 and C equals result bit 31. When a mod 32 is 0, the result is dst unchanged.
- R9: A shift amount is the source's low 8 bits only, and the upper source bits have no effect. An amount of zero returns dst unchanged with C taken from `cflag_i`.
- R10: ADC gives dst+src+C_in, with C the carry out of bit 31 and V set when both operands share a sign that the result lacks. CMN gives the same value and flags as ADC with a carry-in of 0.
- R11: SBC gives dst minus S, where S = src - C_in + 1 is formed in 33 bits. C is set when S <= dst. V is bit 31 of ((dst^res) & (~src^res)).
- R12: CMP gives dst-src, with C set when src <= dst and V as in R11. NEG gives 0-src, with C set only when src is zero and V as in R11 with 0 as the left operand.
- R13: MUL gives the low 32 bits of dst*src and passes C and V through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encoding in R1) |
| dst_i | input | 32 | Destination register value, the left operand |
| src_i | input | 32 | Source register value, the right operand and shift amount |
| cflag_i | input | 1 | Current carry flag |
| vflag_i | input | 1 | Current overflow flag |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest cases are shift amounts at or beyond the word width, and source words whose low byte is zero while the upper bits are not. Random operands almost never produce either. The stimulus therefore crosses every opcode and both incoming flag values with a fixed set of awkward amounts: 0, 1, 31, 32, 33, 64, 255, 256 and 0x120. It also uses operands near the sign boundary, including an all-ones source with carry clear, which pushes the 33-bit SBC subtrahend past the 32-bit range. A behavioural model in the bench predicts every output each cycle.

// File: rtl/cr_alu_pkg.sv
package cr_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_LSL = 4'h2, OP_LSR = 4'h3,
        OP_ASR = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_ROR = 4'h7,
        OP_TST = 4'h8, OP_NEG = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MUL = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {GRP_LOGIC, GRP_SHIFT, GRP_ARITH, GRP_MUL} alu_grp_e;

    typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_kind_e;

    typedef enum logic [2:0] {AS_ADC, AS_CMN, AS_SBC, AS_CMP, AS_NEG} as_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        alu_grp_e    grp;
        shift_kind_e sh;
        as_mode_e    as;
        logic        wr;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(alu_op_e op);
        alu_ctrl_t c;
        c.grp = GRP_LOGIC;
        c.sh  = SH_LSL;
        c.as  = AS_ADC;
        c.wr  = 1'b1;
        case (op)
            OP_LSL: begin c.grp = GRP_SHIFT; c.sh = SH_LSL; end
            OP_LSR: begin c.grp = GRP_SHIFT; c.sh = SH_LSR; end
            OP_ASR: begin c.grp = GRP_SHIFT; c.sh = SH_ASR; end
            OP_ROR: begin c.grp = GRP_SHIFT; c.sh = SH_ROR; end
            OP_ADC: begin c.grp = GRP_ARITH; c.as = AS_ADC; end
            OP_SBC: begin c.grp = GRP_ARITH; c.as = AS_SBC; end
            OP_NEG: begin c.grp = GRP_ARITH; c.as = AS_NEG; end
            OP_CMP: begin c.grp = GRP_ARITH; c.as = AS_CMP; c.wr = 1'b0; end
            OP_CMN: begin c.grp = GRP_ARITH; c.as = AS_CMN; c.wr = 1'b0; end
            OP_TST: c.wr = 1'b0;
            OP_MUL: c.grp = GRP_MUL;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
    import cr_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    always_comb begin
        case (op)
            OP_EOR:  res = a ^ b;
            OP_ORR:  res = a | b;
            OP_BIC:  res = a & ~b;
            OP_MVN:  res = ~b;
            default: res = a & b;
        endcase
    end

endmodule

// File: rtl/cr_shift_unit.sv
module cr_shift_unit
    import cr_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  shift_kind_e      kind,
    input  logic [W-1:0]     val,
    input  logic [AMT_W-1:0] amt,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);

    localparam int               IDX_W = $clog2(W);
    localparam logic [AMT_W-1:0] FULL  = AMT_W'(W);

    logic [W:0]       lsl_ext;
    logic [W:0]       lsr_ext;
    logic [W:0]       asr_ext;
    logic [AMT_W-1:0] asr_amt;
    logic [IDX_W-1:0] rot;
    logic [W-1:0]     ror_v;

    always_comb begin
        // carry rides in the extra bit of each widened shift
        lsl_ext = {1'b0, val} << amt;
        lsr_ext = {val, 1'b0} >> amt;
        asr_amt = (amt > FULL) ? FULL : amt;
        asr_ext = $signed({val, 1'b0}) >>> asr_amt;
        rot     = amt[IDX_W-1:0];
        ror_v   = (val >> rot) | (val << (W - int'(rot)));
        case (kind)
            SH_LSL:  begin res = lsl_ext[W-1:0]; cout = lsl_ext[W]; end
            SH_LSR:  begin res = lsr_ext[W:1];   cout = lsr_ext[0]; end
            SH_ASR:  begin res = asr_ext[W:1];   cout = asr_ext[0]; end
            default: begin res = ror_v;          cout = ror_v[W-1]; end
        endcase
        if (amt == '0) begin
            res  = val;
            cout = cin;
        end
    end

    always_comb begin
        if (kind == SH_LSL && amt > FULL)
            AST_LSL_BEYOND_ZERO: assert (res == '0 && !cout); // R5
        if (kind == SH_ASR && amt >= FULL)
            AST_ASR_SIGN_FILL: assert (res == {W{val[W-1]}} && cout == val[W-1]); // R7
    end

endmodule

// File: rtl/cr_addsub_unit.sv
module cr_addsub_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/cr_mul_unit.sv
module cr_mul_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo
);

    always_comb lo = a * b;

endmodule

// File: rtl/cr_reg_alu.sv
module cr_reg_alu
    import cr_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic             cflag_i,
    input  logic             vflag_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [3:0]       flags_o
);

    alu_op_e          op;
    alu_ctrl_t        ctrl;
    flags_t           nxt;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    logic [WIDTH-1:0] as_a;
    logic [WIDTH-1:0] as_b;
    logic             as_cin;
    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic             as_ovf;
    logic [WIDTH-1:0] mul_res;

    assign op   = alu_op_e'(op_i);
    assign ctrl = decode_op(op);

    cr_logic_unit #(.W(WIDTH)) u_logic (
        .op(op), .a(dst_i), .b(src_i), .res(logic_res)
    );

    cr_shift_unit #(.W(WIDTH), .AMT_W(AMT_W)) u_shift (
        .kind(ctrl.sh), .val(dst_i), .amt(src_i[AMT_W-1:0]), .cin(cflag_i),
        .res(sh_res), .cout(sh_c)
    );

    // subtraction is a + ~b + carry; the carry-in picks borrow or not
    always_comb begin
        as_a   = dst_i;
        as_b   = src_i;
        as_cin = cflag_i;
        case (ctrl.as)
            AS_CMN:  as_cin = 1'b0;
            AS_SBC:  as_b   = ~src_i;
            AS_CMP:  begin as_b = ~src_i; as_cin = 1'b1; end
            AS_NEG:  begin as_a = '0; as_b = ~src_i; as_cin = 1'b1; end
            default: ;
        endcase
    end

    cr_addsub_unit #(.W(WIDTH)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    cr_mul_unit #(.W(WIDTH)) u_mul (
        .a(dst_i), .b(src_i), .lo(mul_res)
    );

    always_comb begin
        nxt.c = cflag_i;
        nxt.v = vflag_i;
        case (ctrl.grp)
            GRP_SHIFT: begin result_o = sh_res; nxt.c = sh_c; end
            GRP_ARITH: begin result_o = as_sum; nxt.c = as_cout; nxt.v = as_ovf; end
            GRP_MUL:   result_o = mul_res;
            default:   result_o = logic_res;
        endcase
        nxt.n   = result_o[WIDTH-1];
        nxt.z   = (result_o == '0);
        flags_o = nxt;
        wr_en_o = ctrl.wr;
    end

    always_comb begin
        if (op_i == 4'h8 || op_i == 4'hA || op_i == 4'hB)
            AST_COMPARE_NO_WRITE: assert (!wr_en_o); // R3
        AST_ZERO_FLAG_TRACKS: assert (flags_o[2] == (result_o == '0)); // R2
        if (op_i == 4'hD)
            AST_MUL_KEEPS_CV: assert (flags_o[1] == cflag_i && flags_o[0] == vflag_i); // R13
        if (op_i == 4'h9)
            AST_NEG_CARRY_ZERO: assert (flags_o[1] == (src_i == '0)); // R12
        if (op_i == 4'h0 || op_i == 4'h1 || op_i == 4'hC || op_i == 4'hE || op_i == 4'hF)
            AST_LOGIC_KEEPS_CV: assert (flags_o[1] == cflag_i && flags_o[0] == vflag_i); // R4
    end

endmodule

// File: tb/cr_reg_alu_bench.sv
`timescale 1ns/1ps
module cr_reg_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic        cflag_i = 1'b0;
    logic        vflag_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cr_reg_alu u_cr_reg_alu (
        .op_i(op_i), .dst_i(dst_i), .src_i(src_i), .cflag_i(cflag_i), .vflag_i(vflag_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    // behavioural model: {wr, N, Z, C, V, result}
    function automatic logic [36:0] model(logic [3:0] op, logic [31:0] d, logic [31:0] s,
                                          logic ci, logic vi);
        logic [31:0] r = '0;
        logic c = ci, v = vi, wr = 1'b1;
        logic [63:0] t;
        int a = int'(s[7:0]);
        int k;
        case (op)
            4'h0: r = d & s;
            4'h1: r = d ^ s;
            4'h8: begin r = d & s; wr = 1'b0; end
            4'hC: r = d | s;
            4'hE: r = d & ~s;
            4'hF: r = ~s;
            4'h2: begin
                if (a == 0) r = d;
                else if (a < 32) begin r = d << a; c = d[32-a]; end
                else if (a == 32) begin r = 0; c = d[0]; end
                else begin r = 0; c = 0; end
            end
            4'h3: begin
                if (a == 0) r = d;
                else if (a < 32) begin r = d >> a; c = d[a-1]; end
                else if (a == 32) begin r = 0; c = d[31]; end
                else begin r = 0; c = 0; end
            end
            4'h4: begin
                if (a == 0) r = d;
                else if (a < 32) begin r = 32'($signed(d) >>> a); c = d[a-1]; end
                else begin r = {32{d[31]}}; c = d[31]; end
            end
            4'h7: begin
                if (a == 0) r = d;
                else begin
                    k = a % 32;
                    r = (k == 0) ? d : ((d >> k) | (d << (32 - k)));
                    c = r[31];
                end
            end
            4'h5, 4'hB: begin
                t = {32'd0, d} + {32'd0, s} + ((op == 4'h5) ? {63'd0, ci} : 64'd0);
                r = t[31:0]; c = t[32];
                v = ((d ^ r) & (s ^ r)) >> 31 != 0;
                if (op == 4'hB) wr = 1'b0;
            end
            4'h6: begin
                t = {32'd0, s} - {63'd0, ci} + 64'd1;
                r = d - t[31:0];
                c = t <= {32'd0, d};
                v = ((d ^ r) & (~s ^ r)) >> 31 != 0;
            end
            4'h9: begin
                r = 32'd0 - s; c = (s == 0);
                v = (r & (~s ^ r)) >> 31 != 0;
            end
            4'hA: begin
                r = d - s; c = (s <= d); wr = 1'b0;
                v = ((d ^ r) & (~s ^ r)) >> 31 != 0;
            end
            default: begin t = {32'd0, d} * {32'd0, s}; r = t[31:0]; end
        endcase
        return {wr, r[31], r == 0, c, v, r};
    endfunction

    function automatic string req_tag(logic [3:0] op, logic [31:0] s);
        if ((op == 4'h2 || op == 4'h3 || op == 4'h4 || op == 4'h7) && s[7:0] == 0) return "R9";
        case (op)
            4'h2: return "R5";
            4'h3: return "R6";
            4'h4: return "R7";
            4'h7: return "R8";
            4'h5, 4'hB: return "R10";
            4'h6: return "R11";
            4'h9, 4'hA: return "R12";
            4'hD: return "R13";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s op=%h d=%h s=%h c=%b v=%b : actual=%h expected=%h",
                     req, what, op_i, dst_i, src_i, cflag_i, vflag_i, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [31:0] d, logic [31:0] s, logic ci, logic vi);
        logic [36:0] e;
        string tag;
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; cflag_i = ci; vflag_i = vi;
        @(posedge clk);
        #1;
        e = model(op, d, s, ci, vi);
        tag = req_tag(op, s);
        check(tag, "result", result_o, e[31:0]);
        check("R3", "write-enable", {31'd0, wr_en_o}, {31'd0, e[36]});
        check("R2", "N/Z", {30'd0, flags_o[3:2]}, {30'd0, e[35:34]});
        check((tag == "R1") ? "R4" : tag, "C/V", {30'd0, flags_o[1:0]}, {30'd0, e[33:32]});
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                              32'hffffffff, 32'h12345678, 32'hf0f0f0f0, 32'h80000001};
    logic [31:0] amts [10] = '{32'h0, 32'h1, 32'h4, 32'h1f, 32'h20, 32'h21,
                               32'h40, 32'hff, 32'h100, 32'h120};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        apply(4'h0, 32'h0, 32'h0, 1'b0, 1'b0);  // reset-state inputs: zero result, Z set (R2)
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int f = 0; f < 4; f++)
                        apply(4'(op), vals[i], vals[j], f[1], f[0]);
        // shift amounts at and past the word width, and high source bits with zero low byte (R5..R9)
        for (int op = 2; op < 8; op++) begin
            if (op == 5 || op == 6) continue;
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 10; j++)
                    for (int f = 0; f < 4; f++)
                        apply(4'(op), vals[i], amts[j] | 32'habcd0000, f[1], f[0]);
        end
        // SBC with all-ones source and carry clear: 33-bit subtrahend (R11)
        apply(4'h6, 32'hffffffff, 32'hffffffff, 1'b0, 1'b0);
        for (int n = 0; n < 3000; n++)
            apply(4'($urandom), $urandom, (n % 3 == 0) ? ($urandom % 70) : $urandom,
                  1'($urandom), 1'($urandom));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule